// File: doc/BRIEF.md
# Software-Forced SDRAM Command Issuer

This block lets software push single commands onto an SDRAM command bus outside the normal read and write traffic. The block has one register write port. A write stores a chip-select selector, a three-bit mode/bank selector, a precharge-all flag and a mode value. The same write can also raise any of three request flags: precharge, refresh and mode register set. Each raised flag stays pending until the block has issued its command. Each flag reads back on a status output, so software can poll for completion.

The controller's command arbiter drives a grant input when the command slot is free. On a grant, the block picks one pending request by a fixed priority and registers it onto the bus for one cycle. It then clears that request and holds the bus at NOP for a parameterised number of cycles before it can issue another forced command. The selector field has a different meaning for each command. For a mode register set it names the target mode register. For a single-bank precharge it names the bank. For a precharge-all or a refresh it is ignored.

Top module: `sdram_force_cmd`

## Requirements
- R1: After reset, all request flags read 0 and the bus shows NOP: every cmd_cs_n bit is 1 and ras/cas/we are 1, with cmd_ba and cmd_addr at 0.
- R2: The chip-select selector decodes as follows: 0 to 3 select chip 0 to 3 alone, 4 selects chips 0 and 1, 5 selects chips 2 and 3, and 6 and 7 select chip 3. During a forced command only the decoded chips have cmd_cs_n low. Bit i of cmd_cs_n belongs to chip i.
- R3: A mode register set drives ras, cas and we all low. cmd_ba equals the stored selector (0 MR, 1 EMR, 2 EMR2, 3 EMR3) and cmd_addr equals the stored mode value.
- R4: A request flag written as 1 reads 1 on its status output until its command is issued, and reads 0 from the cycle the command appears. A write with all request bits at 0 issues nothing.
- R5: A pending command is issued only when grant is sampled high. It appears on the bus in the cycle after that sampling edge. While grant is low the bus stays at NOP and the flags stay set.
- R6: When several flags are pending, precharge goes first, then refresh, then mode register set. Only one command is issued per grant.
- R7: After each forced command, the bus shows NOP for exactly GAP cycles before the next forced command, even with grant held high.
- R8: A precharge drives ras and we low and cas high. A single-bank precharge puts the selector on cmd_ba and drives cmd_addr to 0, so A10 is low. A precharge-all drives cmd_addr to 0 except A10, which is high, and drives cmd_ba to 0 whatever the selector holds.
- R9: A refresh drives ras and cas low and we high, and drives cmd_ba and cmd_addr to 0 whatever the selector holds.
- R10: Every write reloads the chip-select selector, the mode/bank selector, the precharge-all flag and the mode value. The command issued uses the values stored at the time of issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_pre | input | 1 | Raise precharge request |
| wr_ref | input | 1 | Raise refresh request |
| wr_mrs | input | 1 | Raise mode register set request |
| wr_pre_all | input | 1 | Precharge targets all banks |
| wr_cs_sel | input | 3 | Chip-select selector |
| wr_sel | input | 3 | Mode register / bank selector |
| wr_value | input | ADDR_W | Mode value for address bus |
| grant | input | 1 | Command slot free this cycle |
| cmd_cs_n | output | 4 | Active-low chip selects |
| cmd_ras_n | output | 1 | Active-low row strobe |
| cmd_cas_n | output | 1 | Active-low column strobe |
| cmd_we_n | output | 1 | Active-low write enable |
| cmd_ba | output | 3 | Bank address |
| cmd_addr | output | ADDR_W | Address bus |
| stat_pre | output | 1 | Precharge request pending |
| stat_ref | output | 1 | Refresh request pending |
| stat_mrs | output | 1 | Mode register set pending |

## Verification
The bench sweeps all eight chip-select codes against every command variant. This catches a decoder that mishandles the paired codes or the duplicated codes 6 and 7. It also catches a refresh or precharge-all that leaks the selector onto the bank pins, and a precharge whose A10 is inverted. One test raises all three requests at once with grant held high. It checks the issue order and that the bus shows exactly GAP NOP cycles between commands. A design with the wrong priority, a gap one cycle short or long, or two commands per grant fails that test. Other tests hold grant low and confirm the flags stay set, and write with no request bits raised to confirm nothing is issued.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    localparam int CS_NUM = 4;
    localparam int SEL_W  = 3;
    localparam int BA_W   = 3;

    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_PRE  = 2'd1,
        PICK_REF  = 2'd2,
        PICK_MRS  = 2'd3
    } pick_e;

    // Packed ordering: cs_n, ras_n, cas_n, we_n
    typedef struct packed {
        logic [CS_NUM-1:0] cs_n;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
    } ctl_t;
endpackage

// File: rtl/sfc_cs_decode.sv
module sfc_cs_decode
    import sfc_pkg::*;
(
    input  logic [SEL_W-1:0]  cs_sel,
    output logic [CS_NUM-1:0] cs_on
);
    always_comb begin
        cs_on = '0;
        unique case (cs_sel)
            3'd0, 3'd1, 3'd2, 3'd3: cs_on[cs_sel[1:0]] = 1'b1;
            3'd4:                   cs_on = 4'b0011;
            3'd5:                   cs_on = 4'b1100;
            default:                cs_on = 4'b1000;
        endcase
    end
endmodule

// File: rtl/sfc_sched.sv
module sfc_sched
    import sfc_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int GAP    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_pre,
    input  logic              wr_ref,
    input  logic              wr_mrs,
    input  logic              wr_pre_all,
    input  logic [SEL_W-1:0]  wr_cs_sel,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [ADDR_W-1:0] wr_value,
    input  logic              grant,
    output pick_e             pick,
    output logic [SEL_W-1:0]  cur_cs_sel,
    output logic [SEL_W-1:0]  cur_sel,
    output logic [ADDR_W-1:0] cur_value,
    output logic              cur_pre_all,
    output logic              pend_pre,
    output logic              pend_ref,
    output logic              pend_mrs
);
    localparam int GAP_W = (GAP < 1) ? 1 : $clog2(GAP + 1);

    typedef struct packed {
        logic              pre;
        logic              rf;
        logic              mrs;
        logic              pre_all;
        logic [SEL_W-1:0]  cs_sel;
        logic [SEL_W-1:0]  sel;
        logic [ADDR_W-1:0] value;
        logic [GAP_W-1:0]  gap;
    } st_t;

    st_t   st_q, st_d;
    pick_e pick_d;

    always_comb begin
        st_d   = st_q;
        pick_d = PICK_NONE;
        if (st_q.gap != '0) begin
            st_d.gap = st_q.gap - 1'b1;
        end else if (grant) begin
            if (st_q.pre)      pick_d = PICK_PRE;
            else if (st_q.rf)  pick_d = PICK_REF;
            else if (st_q.mrs) pick_d = PICK_MRS;
        end
        if (pick_d != PICK_NONE) begin
            st_d.gap = GAP_W'(GAP);
        end
        unique case (pick_d)
            PICK_PRE: st_d.pre = 1'b0;
            PICK_REF: st_d.rf  = 1'b0;
            PICK_MRS: st_d.mrs = 1'b0;
            default:  ;
        endcase
        if (wr_en) begin
            st_d.cs_sel  = wr_cs_sel;
            st_d.sel     = wr_sel;
            st_d.value   = wr_value;
            st_d.pre_all = wr_pre_all;
            if (wr_pre) st_d.pre = 1'b1;
            if (wr_ref) st_d.rf  = 1'b1;
            if (wr_mrs) st_d.mrs = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pick        = pick_d;
    assign cur_cs_sel  = st_q.cs_sel;
    assign cur_sel     = st_q.sel;
    assign cur_value   = st_q.value;
    assign cur_pre_all = st_q.pre_all;
    assign pend_pre    = st_q.pre;
    assign pend_ref    = st_q.rf;
    assign pend_mrs    = st_q.mrs;

    // R5: nothing issues without the grant
    a_r5_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (pick != PICK_NONE) |-> grant);
    // R6: fixed ordering among pending requests
    a_r6_ref_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
        (pick == PICK_REF) |-> !pend_pre);
    a_r6_mrs_last: assert property (@(posedge clk) disable iff (!rst_n)
        (pick == PICK_MRS) |-> (!pend_pre && !pend_ref));
    // R4: issued request clears unless rewritten
    a_r4_pre_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pick == PICK_PRE && !(wr_en && wr_pre)) |=> !pend_pre);
    a_r4_ref_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (pick == PICK_REF && !(wr_en && wr_ref)) |=> !pend_ref);

    generate
        if (GAP > 0) begin : g_gap_chk
            // R7: no back-to-back forced commands
            a_r7_gap_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
                (pick != PICK_NONE) |=> (pick == PICK_NONE));
        end
    endgenerate
endmodule

// File: rtl/sfc_cmd_out.sv
module sfc_cmd_out
    import sfc_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pick_e             pick,
    input  logic [CS_NUM-1:0] cs_on,
    input  logic [SEL_W-1:0]  sel,
    input  logic [ADDR_W-1:0] value,
    input  logic              pre_all,
    output ctl_t              ctl,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr
);
    localparam int A10 = 10;

    typedef struct packed {
        ctl_t              ctl;
        logic [BA_W-1:0]   ba;
        logic [ADDR_W-1:0] addr;
    } bus_t;

    localparam bus_t BUS_NOP = '{ctl: '{cs_n: '1, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1},
                                 ba: '0, addr: '0};

    bus_t bus_q, bus_d;

    always_comb begin
        bus_d = BUS_NOP;
        if (pick != PICK_NONE) begin
            bus_d.ctl.cs_n = ~cs_on;
        end
        unique case (pick)
            PICK_MRS: begin
                bus_d.ctl.ras_n = 1'b0;
                bus_d.ctl.cas_n = 1'b0;
                bus_d.ctl.we_n  = 1'b0;
                bus_d.ba        = BA_W'(sel);
                bus_d.addr      = value;
            end
            PICK_PRE: begin
                bus_d.ctl.ras_n = 1'b0;
                bus_d.ctl.we_n  = 1'b0;
                if (pre_all) bus_d.addr[A10] = 1'b1;
                else         bus_d.ba        = BA_W'(sel);
            end
            PICK_REF: begin
                bus_d.ctl.ras_n = 1'b0;
                bus_d.ctl.cas_n = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bus_q <= BUS_NOP;
        else        bus_q <= bus_d;
    end

    assign ctl  = bus_q.ctl;
    assign ba   = bus_q.ba;
    assign addr = bus_q.addr;

    // R8: precharge-all keeps the bank pins at zero
    a_r8_pre_all_ba: assert property (@(posedge clk) disable iff (!rst_n)
        (pick == PICK_PRE && pre_all) |=> (ba == '0 && addr[A10]));
    // R9: refresh carries no address
    a_r9_ref_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (pick == PICK_REF) |=> (ba == '0 && addr == '0));
endmodule

// File: rtl/sdram_force_cmd.sv
module sdram_force_cmd
    import sfc_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int GAP    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_pre,
    input  logic              wr_ref,
    input  logic              wr_mrs,
    input  logic              wr_pre_all,
    input  logic [2:0]        wr_cs_sel,
    input  logic [2:0]        wr_sel,
    input  logic [ADDR_W-1:0] wr_value,
    input  logic              grant,
    output logic [3:0]        cmd_cs_n,
    output logic              cmd_ras_n,
    output logic              cmd_cas_n,
    output logic              cmd_we_n,
    output logic [2:0]        cmd_ba,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              stat_pre,
    output logic              stat_ref,
    output logic              stat_mrs
);
    pick_e             pick;
    logic [SEL_W-1:0]  cur_cs_sel, cur_sel;
    logic [ADDR_W-1:0] cur_value;
    logic              cur_pre_all;
    logic [CS_NUM-1:0] cs_on;
    ctl_t              ctl;

    sfc_sched #(.ADDR_W(ADDR_W), .GAP(GAP)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_pre     (wr_pre),
        .wr_ref     (wr_ref),
        .wr_mrs     (wr_mrs),
        .wr_pre_all (wr_pre_all),
        .wr_cs_sel  (wr_cs_sel),
        .wr_sel     (wr_sel),
        .wr_value   (wr_value),
        .grant      (grant),
        .pick       (pick),
        .cur_cs_sel (cur_cs_sel),
        .cur_sel    (cur_sel),
        .cur_value  (cur_value),
        .cur_pre_all(cur_pre_all),
        .pend_pre   (stat_pre),
        .pend_ref   (stat_ref),
        .pend_mrs   (stat_mrs)
    );

    sfc_cs_decode u_csdec (
        .cs_sel (cur_cs_sel),
        .cs_on  (cs_on)
    );

    sfc_cmd_out #(.ADDR_W(ADDR_W)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .pick    (pick),
        .cs_on   (cs_on),
        .sel     (cur_sel),
        .value   (cur_value),
        .pre_all (cur_pre_all),
        .ctl     (ctl),
        .ba      (cmd_ba),
        .addr    (cmd_addr)
    );

    assign cmd_cs_n  = ctl.cs_n;
    assign cmd_ras_n = ctl.ras_n;
    assign cmd_cas_n = ctl.cas_n;
    assign cmd_we_n  = ctl.we_n;

    // R2: at most a pair of chips is ever selected
    a_r2_cs_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cmd_cs_n) <= 2);
    // R1: a deselected bus carries a NOP
    a_r1_idle_nop: assert property (@(posedge clk) disable iff (!rst_n)
        (&cmd_cs_n) |-> (cmd_ras_n && cmd_cas_n && cmd_we_n));
endmodule

// File: tb/sdram_force_cmd_test.sv
module sdram_force_cmd_test;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 14;
    localparam int GAP = 2;
    localparam int BW = 4 + 3 + 3 + ADDR_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 0, wr_pre = 0, wr_ref = 0, wr_mrs = 0, wr_pre_all = 0;
    logic [2:0] wr_cs_sel = 0, wr_sel = 0;
    logic [ADDR_W-1:0] wr_value = 0;
    logic grant = 0;
    logic [3:0] cmd_cs_n;
    logic cmd_ras_n, cmd_cas_n, cmd_we_n;
    logic [2:0] cmd_ba;
    logic [ADDR_W-1:0] cmd_addr;
    logic stat_pre, stat_ref, stat_mrs;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_force_cmd #(.ADDR_W(ADDR_W), .GAP(GAP)) uut (.*);

    function automatic logic [3:0] cs_exp(input int c);
        if (c < 4)       return ~(4'b1 << c);
        else if (c == 4) return 4'b1100;
        else if (c == 5) return 4'b0011;
        else             return 4'b0111;
    endfunction

    // kind: 0 nop, 1 pre, 2 ref, 3 mrs
    function automatic logic [BW-1:0] bus_exp(input int kind, input int c, input int sel,
                                              input bit all, input logic [ADDR_W-1:0] v);
        logic [3:0] cs;
        logic [2:0] rcw;
        logic [2:0] ba;
        logic [ADDR_W-1:0] a;
        cs = 4'hF; rcw = 3'b111; ba = 0; a = 0;
        if (kind != 0) cs = cs_exp(c);
        if (kind == 1) begin
            rcw = 3'b010;
            if (all) a = ADDR_W'(1 << 10); else ba = 3'(sel);
        end else if (kind == 2) begin
            rcw = 3'b001;
        end else if (kind == 3) begin
            rcw = 3'b000; ba = 3'(sel); a = v;
        end
        return {cs, rcw, ba, a};
    endfunction

    function automatic logic [BW-1:0] bus_now();
        return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, cmd_ba, cmd_addr};
    endfunction

    task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input bit p, input bit r, input bit m, input bit all,
                      input int c, input int sel, input logic [ADDR_W-1:0] v);
        @(negedge clk);
        wr_en = 1; wr_pre = p; wr_ref = r; wr_mrs = m; wr_pre_all = all;
        wr_cs_sel = 3'(c); wr_sel = 3'(sel); wr_value = v;
        @(negedge clk);
        wr_en = 0; wr_pre = 0; wr_ref = 0; wr_mrs = 0;
    endtask

    task automatic one_op(input int kind, input int c, input int sel, input bit all,
                          input logic [ADDR_W-1:0] v);
        wr(kind == 1, kind == 2, kind == 3, all, c, sel, v);
        // R4: flag reads set while pending
        check("R4 pending", BW'({stat_pre, stat_ref, stat_mrs}),
              BW'({kind == 1, kind == 2, kind == 3}));
        grant = 1;
        @(negedge clk);
        grant = 0;
        check(kind == 3 ? "R2/R3 mrs" : (kind == 1 ? "R2/R8 pre" : "R2/R9 ref"),
              bus_now(), bus_exp(kind, c, sel, all, v));
        check("R4 cleared", BW'({stat_pre, stat_ref, stat_mrs}), '0);
        repeat (GAP + 1) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset bus", bus_now(), bus_exp(0, 0, 0, 0, 0));
        check("R1 reset flags", BW'({stat_pre, stat_ref, stat_mrs}), '0);
        rst_n = 1;
        @(negedge clk);

        // R2 R3 R8 R9 R10: sweep every chip-select code against every command
        for (int c = 0; c < 8; c++) begin
            for (int s = 0; s < 4; s++)
                one_op(3, c, s, 0, ADDR_W'(c * 1031 + s * 97 + 5));
            one_op(1, c, 7 - c, 0, '0);
            one_op(1, c, c, 1, '0);
            one_op(2, c, 7 - c, 0, ADDR_W'(16'h3ABC));
        end

        // R4: write with no request bits issues nothing
        wr(0, 0, 0, 0, 2, 1, ADDR_W'(123));
        grant = 1;
        repeat (2) @(negedge clk);
        check("R4 no request", bus_now(), bus_exp(0, 0, 0, 0, 0));
        grant = 0;

        // R5: grant low keeps request pending and bus idle
        wr(0, 1, 0, 0, 1, 0, '0);
        repeat (4) @(negedge clk);
        check("R5 no grant bus", bus_now(), bus_exp(0, 0, 0, 0, 0));
        check("R5 no grant flag", BW'(stat_ref), BW'(1));
        grant = 1;
        @(negedge clk);
        check("R5 grant issue", bus_now(), bus_exp(2, 1, 0, 0, 0));
        grant = 0;
        repeat (GAP + 1) @(negedge clk);

        // R6 R7: all three pending with grant held high
        wr(1, 1, 1, 0, 4, 3, ADDR_W'(16'h0155));
        grant = 1;
        for (int k = 0; k < 3 * (GAP + 1); k++) begin
            @(negedge clk);
            if (k % (GAP + 1) == 0)
                check("R6 order", bus_now(),
                      bus_exp(k == 0 ? 1 : (k == GAP + 1 ? 2 : 3), 4, 3, 0, ADDR_W'(16'h0155)));
            else
                check("R7 gap nop", bus_now(), bus_exp(0, 0, 0, 0, 0));
        end
        check("R6 all cleared", BW'({stat_pre, stat_ref, stat_mrs}), '0);
        grant = 0;

        // R10: later write updates the fields used for a pending request
        wr(0, 0, 1, 0, 0, 0, ADDR_W'(1));
        wr(0, 0, 0, 0, 5, 2, ADDR_W'(16'h0777));
        grant = 1;
        @(negedge clk);
        grant = 0;
        check("R10 reload", bus_now(), bus_exp(3, 5, 2, 0, ADDR_W'(16'h0777)));
        repeat (GAP + 1) @(negedge clk);

        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule